// File: doc/BRIEF.md
# Conversion start sequencer

This block sits between an asynchronous convert-start pin and the conversion engine of a sampling converter. It brings the pin into the conversion-clock domain and looks for low-to-high transitions. When one arrives, it moves the track/hold into hold and runs a fixed-length conversion. At the end it releases hold and emits a one-cycle end-of-conversion strobe.

Each time the control logic selects a new input channel, it pulses a channel-change strobe. That strobe starts a settling interval whose length in conversion-clock cycles is taken from a programmable length input. A start edge that arrives during this interval is not lost. It is held pending, and the conversion begins on the first cycle after the interval runs out. Start edges that arrive while a conversion is in progress have no effect.

Top module: `cnvstart_seq`

## Requirements
- R1: During and directly after reset, `hold_o`, `busy_o` and `eoc_o` are low.
- R2: If no settling interval is active, a rising convert-start that is driven before clock edge j makes `busy_o` and `hold_o` go high after edge j+2. This latency covers two synchronizer flops and one edge-detect flop.
- R3: If the settling interval is active when the rising edge reaches the controller, the start waits. `busy_o` goes high after the first edge that sees the interval expired. Further rising edges during the wait merge into the single pending start.
- R4: A channel strobe sampled at edge k keeps the interval active after edges k through k+L-1, where L is the value of `settle_len_i` at edge k. L = 0 gives no interval.
- R5: A channel strobe received while the interval is running, or while a start is pending, reloads the interval to the full length L.
- R6: A conversion keeps `busy_o` high for exactly CONV_BITS + SETUP_CYC cycles (14 by default). `hold_o` is high in exactly the same cycles.
- R7: `eoc_o` goes high for exactly one cycle, in the cycle directly after `busy_o` falls. In that cycle `hold_o` is already back low.
- R8: A rising convert-start during a conversion does not start another conversion. A convert-start held high does not start more than one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Asynchronous convert-start; acts on its rising edge only |
| chan_chg_i | input | 1 | One-cycle strobe raised when a new channel has been selected |
| settle_len_i | input | LEN_W | Settling interval length in cycles, sampled at the strobe |
| hold_o | output | 1 | High = hold, low = track |
| busy_o | output | 1 | High while a conversion is in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The assertions assume that `chan_chg_i` and `settle_len_i` are synchronous to `clk`. They also assume that the timer activity seen by the controller is the only thing that can hold back a start. The start-after-settle property reads that internal timer flag through the bind, and it trusts the flag to stay low once the timer has drained. The bench drives all inputs on falling edges and keeps the strobe to one cycle. It keeps the length fixed within each case and leaves long idle gaps between cases, so every case begins with the timer drained and the synchronizer settled low.

// File: rtl/cnvseq_pkg.sv
package cnvseq_pkg;
   typedef enum logic [1:0] {
      SQ_TRACK = 2'd0,
      SQ_WAIT  = 2'd1,
      SQ_CONV  = 2'd2
   } seq_state_t;

   function automatic int conv_total(input int bits, input int setup);
      return bits + setup;
   endfunction
endpackage

// File: rtl/cnvseq_sync.sv
module cnvseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cnvseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cnvseq_settle.sv
module cnvseq_settle #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [LEN_W-1:0] len,
   output logic             active
);
   generate
      if (LEN_W < 1) begin : g_bad
         $error("cnvseq_settle: LEN_W must be positive");
      end
   endgenerate

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (restart)        remain <= len;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/cnvseq_ctrl.sv
module cnvseq_ctrl
   import cnvseq_pkg::*;
#(
   parameter int CONV_BITS = 12,
   parameter int SETUP_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_rise,
   input  logic settle_active,
   output logic hold,
   output logic busy,
   output logic eoc
);
   localparam int TOTAL = conv_total(CONV_BITS, SETUP_CYC);
   localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;

   generate
      if (CONV_BITS < 1 || SETUP_CYC < 0) begin : g_bad
         $error("cnvseq_ctrl: bad conversion length");
      end
   endgenerate

   seq_state_t       state, state_n;
   logic [CW-1:0]    step, step_n;
   logic             eoc_n;
   logic             last_step;

   assign last_step = (step == CW'(TOTAL - 1));

   always_comb begin
      state_n = state;
      step_n  = step;
      eoc_n   = 1'b0;
      unique case (state)
         SQ_TRACK: begin
            if (start_rise) begin
               step_n  = '0;
               state_n = settle_active ? SQ_WAIT : SQ_CONV;
            end
         end
         SQ_WAIT: begin
            if (!settle_active) begin
               step_n  = '0;
               state_n = SQ_CONV;
            end
         end
         SQ_CONV: begin
            if (last_step) begin
               state_n = SQ_TRACK;
               step_n  = '0;
               eoc_n   = 1'b1;
            end else begin
               step_n = step + 1'b1;
            end
         end
         default: state_n = SQ_TRACK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_TRACK;
         step  <= '0;
         eoc   <= 1'b0;
      end else begin
         state <= state_n;
         step  <= step_n;
         eoc   <= eoc_n;
      end
   end

   assign busy = (state == SQ_CONV);
   assign hold = busy;
endmodule

// File: rtl/cnvstart_seq.sv
module cnvstart_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = 8,
   parameter int CONV_BITS   = 12,
   parameter int SETUP_CYC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start_i,
   input  logic             chan_chg_i,
   input  logic [LEN_W-1:0] settle_len_i,
   output logic             hold_o,
   output logic             busy_o,
   output logic             eoc_o
);
   logic start_rise;
   logic settle_active;

   cnvseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (conv_start_i),
      .rise (start_rise)
   );

   cnvseq_settle #(.LEN_W(LEN_W)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(chan_chg_i),
      .len    (settle_len_i),
      .active (settle_active)
   );

   cnvseq_ctrl #(.CONV_BITS(CONV_BITS), .SETUP_CYC(SETUP_CYC)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_rise   (start_rise),
      .settle_active(settle_active),
      .hold         (hold_o),
      .busy         (busy_o),
      .eoc          (eoc_o)
   );
endmodule

// File: rtl/cnvstart_seq_chk.sv
module cnvstart_seq_chk #(
   parameter int CONV_BITS = 12,
   parameter int SETUP_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic hold_o,
   input logic busy_o,
   input logic eoc_o,
   input logic settle_active
);
   localparam int TOTAL = CONV_BITS + SETUP_CYC;
   localparam int BW    = $clog2(TOTAL + 2) + 1;

   logic [BW-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len <= '0;
      else if (busy_o) busy_len <= busy_len + 1'b1;
      else             busy_len <= '0;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!hold_o && !busy_o && !eoc_o));

   assert_start_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(settle_active));

   assert_conv_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_len < BW'(TOTAL)));

   assert_conv_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == BW'(TOTAL)));

   assert_eoc_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> eoc_o);

   assert_eoc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |=> !eoc_o);

   assert_eoc_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> (!hold_o && !busy_o));
endmodule

bind cnvstart_seq cnvstart_seq_chk #(.CONV_BITS(CONV_BITS), .SETUP_CYC(SETUP_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hold_o       (hold_o),
   .busy_o       (busy_o),
   .eoc_o        (eoc_o),
   .settle_active(settle_active)
);

// File: tb/cnvstart_seq_tb.sv
`timescale 1ns/1ps
module cnvstart_seq_tb;
   localparam int LEN_W = 8;
   localparam int TOTAL = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             conv_start_i = 1'b0;
   logic             chan_chg_i = 1'b0;
   logic [LEN_W-1:0] settle_len_i = '0;
   logic             hold_o, busy_o, eoc_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cnvstart_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_start_i(conv_start_i),
      .chan_chg_i  (chan_chg_i),
      .settle_len_i(settle_len_i),
      .hold_o      (hold_o),
      .busy_o      (busy_o),
      .eoc_o       (eoc_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit win_on(input int n, input int k, input int len,
                                 input int k2);
      bit a;
      a = (n >= k && n < k + len && (k2 < 0 || n < k2));
      if (k2 >= 0 && n >= k2 && n < k2 + len) a = 1'b1;
      return a;
   endfunction

   // dc: strobe iteration, dc2: optional reload iteration (-1 none),
   // dj: convert-start high iteration; second pulse 6 later.
   task automatic run_case(input int len, input int dc, input int dc2, input int dj);
      int k, k2, j, s, first_busy, n_busy, eoc_at, n_eoc, n_hmis;
      bit pend;
      k  = dc + 1;
      k2 = (dc2 >= 0) ? dc2 + 1 : -1;
      j  = dj + 1;
      s  = j + 2;
      pend = win_on(j + 1, k, len, k2);
      while (win_on(s - 1, k, len, k2)) s++;
      first_busy = -1; n_busy = 0; eoc_at = -1; n_eoc = 0; n_hmis = 0;
      settle_len_i = LEN_W'(len);
      for (int t = 0; t < 34; t++) begin
         @(negedge clk);
         if (busy_o) begin
            n_busy++;
            if (first_busy < 0) first_busy = t;
         end
         if (eoc_o) begin
            n_eoc++;
            if (eoc_at < 0) eoc_at = t;
            if (hold_o) n_hmis++;
         end
         if (hold_o != busy_o) n_hmis++;
         chan_chg_i   = (t == dc) || (t == dc2);
         conv_start_i = (t >= dj && t < dj + 4) || (t >= dj + 6 && t < dj + 10);
      end
      conv_start_i = 1'b0;
      chan_chg_i   = 1'b0;
      if (dc2 >= 0)  chk("R5 reload delays start", first_busy, s);
      else if (pend) chk("R3 R4 deferred start", first_busy, s);
      else           chk("R2 immediate start", first_busy, s);
      chk("R6 R8 busy cycles", n_busy, TOTAL);
      chk("R7 eoc position", eoc_at, s + TOTAL);
      chk("R7 eoc width", n_eoc, 1);
      chk("R6 R7 hold vs busy", n_hmis, 0);
      repeat (12) @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 hold in reset", int'(hold_o), 0);
      chk("R1 busy in reset", int'(busy_o), 0);
      chk("R1 eoc in reset", int'(eoc_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 idle after reset", int'(busy_o | hold_o | eoc_o), 0);

      for (int len = 0; len < 6; len++)
         for (int dc = 0; dc < 3; dc++)
            for (int dj = 0; dj < 8; dj++)
               run_case(len, dc, -1, dj);

      for (int dj = 0; dj < 5; dj++)
         run_case(5, 0, 3, dj);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule